// File: doc/BRIEF.md
# Gated Frequency Counter with Prescaled Timebase

This block measures the frequency of an asynchronous intermediate-frequency input by counting its rising edges over a programmable measurement window. The system reference clock (nominally 10 MHz) is divided by a fixed prescale factor to form a 2 MHz timebase. A select input can replace it with an alternate, slower host clock. A gate timer counts timebase ticks and holds an active-low gate output low for a period set by a decade resolution code.

While the gate is low, synchronized input edges advance an 8-bit low counter made of two cascaded 4-bit stages. Each wrap of the low counter from its top value back to zero advances a wider high counter. The measured edge count is therefore high × 256 + low. When the gate closes, an end-of-count interrupt is raised if the host's arm bit is high. A wrap of the high counter sets a sticky overflow interrupt.

The counts stay frozen from gate close until the host starts the next window. The host reads them over a shared read bus: one strobe returns the low count, and a select-plus-read strobe pair returns the high count.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset the gate output is high, both interrupts are low, both counts are zero, and the read bus drives zero.
- R2: A one-cycle start pulse while the gate is closed drives the gate output low on the next clock edge. It also clears both counts, the overflow flag and the pending end-of-count event.
- R3: With the timebase select low, a tick occurs every 5 reference clocks. Resolution codes 0..5 mean 1 MHz, 100 kHz, 10 kHz, 1 kHz, 100 Hz and 10 Hz, and set a window of L = 2·10^code ticks. The gate stays low for between (L-1)·5+1 and L·5 clock cycles.
- R4: With the timebase select high, each rising edge of the alternate clock input is one tick. For an alternate clock period of P reference clocks, the gate stays low for between (L-1)·P+1 and L·P cycles.
- R5: Every rising edge of the signal input that falls inside the gate window is counted exactly once. Edges while the gate is high are not counted.
- R6: The low count holds the edge count modulo 256. The high count advances by one each time the low count wraps from 255 to 0.
- R7: When the high count wraps from its maximum value to zero, the overflow interrupt goes high and stays high until the next accepted start.
- R8: The end-of-count interrupt is high exactly when a gate has closed since the last start and the arm input is high. Driving the arm input low masks it.
- R9: A start pulse while the gate is low is ignored, and the window keeps its original length.
- R10: From gate close until the next start, both counts stay unchanged.
- R11: The read bus behaves as follows. With the low-read strobe low, it carries the low count in bits 7:0 and zeros above. With the low-read strobe high and both the high-select and high-read strobes low, it carries the high count, zero-extended. Otherwise it is zero. The low read takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_clk_i | input | 1 | Alternate host timebase clock, asynchronous |
| tb_sel_i | input | 1 | 0: prescaled reference timebase, 1: alternate clock |
| res_sel_i | input | 3 | Resolution code, 0 = 1 MHz … 5 = 10 Hz |
| start_i | input | 1 | Start-window pulse |
| arm_i | input | 1 | End-of-count interrupt arm bit |
| sig_i | input | 1 | Measured signal, asynchronous |
| gate_n_o | output | 1 | Gate, low while counting |
| eoc_irq_o | output | 1 | End-of-count interrupt |
| ovf_irq_o | output | 1 | High-count overflow interrupt |
| rd_lo_n_i | input | 1 | Low-count read strobe, active low |
| hi_cs_n_i | input | 1 | High-count select, active low |
| hi_rd_n_i | input | 1 | High-count read strobe, active low |
| rd_data_o | output | 16 | Read data bus |

## Verification
The assertions assume three things. Start is only meaningful as a pulse. The timebase select and resolution code are held steady during a window. The measured signal and the alternate clock each stay high and low for at least one reference clock, so the synchronizer catches every edge.

The stimulus drives every input on the falling clock edge. It keeps pulse high and low phases between one and two cycles, and runs the alternate clock at one eighth of the reference rate. It begins pulses four cycles after the gate opens and ends them well before the earliest possible close, so the expected count is exact. The bench instance uses a 4-bit high counter so that overflow is reachable within a short window.

// File: rtl/gfc_pkg.sv
// Package: shared constants and the gate-length function for the
// gated frequency counter. Assumes decade resolution codes 0..5.
package gfc_pkg;

    localparam int unsigned RES_CODE_MAX = 5;

    // Number of timebase ticks in a window for a resolution code.
    function automatic int unsigned gate_ticks(input logic [2:0] code,
                                               input int unsigned base);
        int unsigned val;
        int unsigned lim;
        lim = (int'(code) > RES_CODE_MAX) ? RES_CODE_MAX : int'(code);
        val = base;
        for (int i = 0; i < RES_CODE_MAX; i++) begin
            if (i < lim) val = val * 10;
        end
        return val;
    endfunction

endpackage

// File: rtl/gfc_timebase.sv
// Timebase: divides the reference clock by DIV into a one-cycle tick,
// synchronizes the alternate clock and turns its rising edges into
// ticks, then selects one source. Assumes the alternate clock is
// slower than half the reference clock.
module gfc_timebase #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_clk_i,
    input  logic sel_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;
    logic [2:0]    alt_sync_q;
    logic          ref_tick;
    logic          alt_tick;

    // Free-running prescale counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                       div_q <= '0;
        else if (div_q == CW'(DIV - 1))   div_q <= '0;
        else                              div_q <= div_q + 1'b1;
    end

    // Two-stage synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) alt_sync_q <= '0;
        else        alt_sync_q <= {alt_sync_q[1:0], alt_clk_i};
    end

    // Tick sources and the clock-select multiplexer.
    always_comb begin
        ref_tick = (div_q == CW'(DIV - 1));
        alt_tick = alt_sync_q[1] & ~alt_sync_q[2];
        tick_o   = sel_i ? alt_tick : ref_tick;
    end
endmodule

// File: rtl/gfc_gate_timer.sv
// Gate timer: on an accepted start, loads the window length for the
// latched resolution code and counts ticks down; the window closes on
// the last tick. Starts while the window is open are ignored.
module gfc_gate_timer #(
    parameter int GATE_BASE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       start_i,
    input  logic [2:0] res_i,
    output logic       open_o,
    output logic       begin_o,
    output logic       end_o
);
    localparam int unsigned GATE_MAX = GATE_BASE * 100000;
    localparam int REM_W = $clog2(GATE_MAX + 1);

    logic [REM_W-1:0] remain_q;
    logic             open_q;

    // Window state and remaining-tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q   <= 1'b0;
            remain_q <= '0;
        end else if (begin_o) begin
            open_q   <= 1'b1;
            remain_q <= REM_W'(gfc_pkg::gate_ticks(res_i, GATE_BASE));
        end else if (open_q && tick_i) begin
            if (remain_q <= REM_W'(1)) open_q <= 1'b0;
            remain_q <= remain_q - 1'b1;
        end
    end

    // Start acceptance and close pulse.
    always_comb begin
        begin_o = start_i & ~open_q;
        end_o   = open_q & tick_i & (remain_q <= REM_W'(1));
        open_o  = open_q;
    end
endmodule

// File: rtl/gfc_nibble.sv
// One cascadable counter stage: increments on inc_i, clears on clr_i,
// and raises carry_o when an increment wraps it.
module gfc_nibble #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic         carry_o
);
    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) val_o <= '0;
        else if (inc_i)      val_o <= val_o + 1'b1;
    end

    // Carry to the next stage.
    always_comb carry_o = inc_i & (&val_o);
endmodule

// File: rtl/gfc_event_counter.sv
// Event counter: synchronizes the measured signal, counts its rising
// edges while enabled in cascaded 4-bit stages, advances the high
// counter on each low wrap and flags a high wrap as overflow.
// Assumes the signal holds each level for at least one clock.
module gfc_event_counter #(
    parameter int LO_W   = 8,
    parameter int HI_W   = 16,
    parameter int STG_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_i,
    input  logic            en_i,
    input  logic            clr_i,
    output logic [LO_W-1:0] lo_o,
    output logic [HI_W-1:0] hi_o,
    output logic            ovf_o
);
    localparam int NSTG = LO_W / STG_W;

    logic [2:0]      sig_sync_q;
    logic            cnt_en;
    logic [NSTG-1:0] carry;
    logic [NSTG-1:0] stage_inc;

    // Synchronizer and edge-detect delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_sync_q <= '0;
        else        sig_sync_q <= {sig_sync_q[1:0], sig_i};
    end

    // Gated edge qualifier.
    always_comb cnt_en = en_i & sig_sync_q[1] & ~sig_sync_q[2];

    // Cascaded low-counter stages.
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_inc[g] = cnt_en;
        end else begin : g_next
            assign stage_inc[g] = carry[g-1];
        end
        gfc_nibble #(.W(STG_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_i),
            .inc_i   (stage_inc[g]),
            .val_o   (lo_o[g*STG_W +: STG_W]),
            .carry_o (carry[g])
        );
    end

    // High counter clocked by low wrap, with sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            hi_o  <= '0;
            ovf_o <= 1'b0;
        end else if (carry[NSTG-1]) begin
            hi_o <= hi_o + 1'b1;
            if (&hi_o) ovf_o <= 1'b1;
        end
    end
endmodule

// File: rtl/gated_freq_counter.sv
// Top: gated frequency counter. Ties the timebase, gate timer and
// event counter together, keeps the end-of-count pending flag and
// drives the shared read bus. Assumes res_sel_i and tb_sel_i are
// steady during a window.
module gated_freq_counter #(
    parameter int DIV       = 5,
    parameter int GATE_BASE = 2,
    parameter int LO_W      = 8,
    parameter int HI_W      = 16,
    parameter int BUS_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_clk_i,
    input  logic             tb_sel_i,
    input  logic [2:0]       res_sel_i,
    input  logic             start_i,
    input  logic             arm_i,
    input  logic             sig_i,
    output logic             gate_n_o,
    output logic             eoc_irq_o,
    output logic             ovf_irq_o,
    input  logic             rd_lo_n_i,
    input  logic             hi_cs_n_i,
    input  logic             hi_rd_n_i,
    output logic [BUS_W-1:0] rd_data_o
);
    logic            tick;
    logic            gate_open;
    logic            gate_begin;
    logic            gate_end;
    logic            eoc_pend_q;
    logic [LO_W-1:0] lo_cnt;
    logic [HI_W-1:0] hi_cnt;
    logic            ovf_flag;

    gfc_timebase #(.DIV(DIV)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .alt_clk_i (alt_clk_i),
        .sel_i     (tb_sel_i),
        .tick_o    (tick)
    );

    gfc_gate_timer #(.GATE_BASE(GATE_BASE)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .start_i (start_i),
        .res_i   (res_sel_i),
        .open_o  (gate_open),
        .begin_o (gate_begin),
        .end_o   (gate_end)
    );

    gfc_event_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (sig_i),
        .en_i  (gate_open),
        .clr_i (gate_begin),
        .lo_o  (lo_cnt),
        .hi_o  (hi_cnt),
        .ovf_o (ovf_flag)
    );

    // Pending end-of-count event, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || gate_begin) eoc_pend_q <= 1'b0;
        else if (gate_end)        eoc_pend_q <= 1'b1;
    end

    // Outputs: gate, interrupts and read-bus multiplexer.
    always_comb begin
        gate_n_o  = ~gate_open;
        eoc_irq_o = eoc_pend_q & arm_i;
        ovf_irq_o = ovf_flag;
        if (!rd_lo_n_i)                    rd_data_o = BUS_W'(lo_cnt);
        else if (!hi_cs_n_i && !hi_rd_n_i) rd_data_o = BUS_W'(hi_cnt);
        else                               rd_data_o = '0;
    end
endmodule

// File: rtl/gfc_checker.sv
// Checker: temporal properties of the gated frequency counter, bound
// to every instance of the top module.
module gfc_checker #(
    parameter int LO_W  = 8,
    parameter int HI_W  = 16,
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             arm_i,
    input logic             gate_n_o,
    input logic             eoc_irq_o,
    input logic             ovf_irq_o,
    input logic             rd_lo_n_i,
    input logic             hi_cs_n_i,
    input logic [BUS_W-1:0] rd_data_o,
    input logic [LO_W-1:0]  lo_cnt,
    input logic [HI_W-1:0]  hi_cnt
);
    // R2
    start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_n_o && start_i) |=> (!gate_n_o && lo_cnt == '0 && hi_cnt == '0 && !ovf_irq_o));

    // R8
    eoc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq_o |-> arm_i);

    // R8
    eoc_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_n_o) |-> (eoc_irq_o == arm_i));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq_o && !start_i) |=> ovf_irq_o);

    // R10
    hold_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_n_o && !start_i) |=> ($stable(lo_cnt) && $stable(hi_cnt) && gate_n_o));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_n_o && start_i) |=> ($stable(lo_cnt) || !gate_n_o));

    // R11
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_n_i && hi_cs_n_i) |-> (rd_data_o == '0));
endmodule

bind gated_freq_counter gfc_checker #(.LO_W(LO_W), .HI_W(HI_W), .BUS_W(BUS_W)) u_gfc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .arm_i     (arm_i),
    .gate_n_o  (gate_n_o),
    .eoc_irq_o (eoc_irq_o),
    .ovf_irq_o (ovf_irq_o),
    .rd_lo_n_i (rd_lo_n_i),
    .hi_cs_n_i (hi_cs_n_i),
    .rd_data_o (rd_data_o),
    .lo_cnt    (lo_cnt),
    .hi_cnt    (hi_cnt)
);

// File: tb/test_gated_freq_counter.sv
module test_gated_freq_counter;
    localparam int HI_W = 4;
    localparam int ALT_P = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic alt_clk_i = 0, tb_sel_i = 0, start_i = 0, arm_i = 1, sig_i = 0;
    logic [2:0] res_sel_i = 0;
    logic rd_lo_n_i = 1, hi_cs_n_i = 1, hi_rd_n_i = 1;
    logic gate_n_o, eoc_irq_o, ovf_irq_o;
    logic [15:0] rd_data_o;

    int checks = 0, fails = 0;
    bit done = 0;

    gated_freq_counter #(.HI_W(HI_W)) i_gated_freq_counter (.*);

    always #5 clk = ~clk;

    // Alternate clock, period ALT_P reference cycles.
    initial forever begin
        repeat (ALT_P/2) @(negedge clk);
        alt_clk_i = ~alt_clk_i;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gate_len(input int code);
        int v = 2;
        for (int i = 0; i < code; i++) v = v * 10;
        return v;
    endfunction

    task automatic read_lo(output int v);
        @(negedge clk); rd_lo_n_i = 0; #1 v = rd_data_o; rd_lo_n_i = 1;
    endtask

    task automatic read_hi(output int v);
        @(negedge clk); hi_cs_n_i = 0; hi_rd_n_i = 0; #1 v = rd_data_o;
        hi_cs_n_i = 1; hi_rd_n_i = 1;
    endtask

    task automatic send_pulses(input int n, input bit fast);
        for (int i = 0; i < n; i++) begin
            sig_i = 1;
            repeat (fast ? 1 : 1 + $urandom % 2) @(negedge clk);
            sig_i = 0;
            repeat (fast ? 1 : 1 + $urandom % 2) @(negedge clk);
        end
    endtask

    // Runs one window; pulses start 4 cycles in; optional mid-window start.
    task automatic run_gate(input int code, input int n, input bit fast,
                            input bit restart, output int len);
        res_sel_i = code[2:0];
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        len = 0;
        fork
            begin
                while (gate_n_o == 0) begin len++; @(negedge clk); end
            end
            begin
                repeat (4) @(negedge clk);
                if (restart) begin start_i = 1; @(negedge clk); start_i = 0; end
                send_pulses(n, fast);
            end
        join
        repeat (3) @(negedge clk);
    endtask

    task automatic check_counts(input int n, input string tag);
        int lo, hi;
        read_lo(lo);
        read_hi(hi);
        chk(lo == n % 256, {tag, " R6 R11 low"}, lo, n % 256);
        chk(hi == (n / 256) % (1 << HI_W), {tag, " R6 R11 high"}, hi, (n / 256) % (1 << HI_W));
        chk(ovf_irq_o == (n >= (256 << HI_W)), {tag, " R7 ovf"}, ovf_irq_o, n >= (256 << HI_W));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int len, n, v, L;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(gate_n_o == 1, "R1 gate", gate_n_o, 1);
        chk(eoc_irq_o == 0 && ovf_irq_o == 0, "R1 irqs", {eoc_irq_o, ovf_irq_o}, 0);
        chk(rd_data_o == 0, "R1 bus", rd_data_o, 0);
        @(negedge clk); rst_n = 1;
        read_lo(v); chk(v == 0, "R1 low count", v, 0);
        read_hi(v); chk(v == 0, "R1 high count", v, 0);

        // R3 shortest and 100 kHz windows, count mode
        for (int c = 0; c < 2; c++) begin
            run_gate(c, 0, 0, 0, len);
            L = gate_len(c);
            chk(len >= (L-1)*5+1 && len <= L*5, "R3 gate length", len, L*5);
        end

        // R2 R5 R6 random counts in 1 kHz windows
        for (int k = 0; k < 4; k++) begin
            n = (k == 0) ? 256 : $urandom % 1500;
            run_gate(3, n, 0, 0, len);
            chk(len >= 9996 && len <= 10000, "R3 1kHz length", len, 10000);
            chk(eoc_irq_o == 1, "R8 eoc raised", eoc_irq_o, 1);
            check_counts(n, "R5 random");
        end

        // R7 boundary just below overflow, then overflow
        run_gate(3, (256 << HI_W) - 1, 1, 0, len);
        check_counts((256 << HI_W) - 1, "R7 edge");
        run_gate(3, (256 << HI_W) + 37, 1, 0, len);
        check_counts((256 << HI_W) + 37, "R7 overflow");

        // R5 R10 pulses after close ignored, counts held
        send_pulses(20, 0);
        repeat (5) @(negedge clk);
        check_counts((256 << HI_W) + 37, "R10 hold");

        // R8 arm masking and re-arm
        arm_i = 0; #1 chk(eoc_irq_o == 0, "R8 masked", eoc_irq_o, 0);
        arm_i = 1; #1 chk(eoc_irq_o == 1, "R8 rearmed", eoc_irq_o, 1);

        // R9 start during window ignored; R2 clears on start
        res_sel_i = 2;
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        chk(eoc_irq_o == 0 && ovf_irq_o == 0, "R2 cleared", {eoc_irq_o, ovf_irq_o}, 0);
        len = 1;
        fork
            begin while (gate_n_o == 0) begin len++; @(negedge clk); end end
            begin repeat (100) @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
                  send_pulses(30, 0); end
        join
        chk(len >= 996 && len <= 1001, "R9 window length", len, 1000);
        repeat (3) @(negedge clk);
        check_counts(30, "R9 counts");

        // R4 alternate timebase
        tb_sel_i = 1;
        run_gate(1, 15, 0, 0, len);
        L = gate_len(1);
        chk(len >= (L-1)*ALT_P+1 && len <= L*ALT_P, "R4 alt length", len, L*ALT_P);
        check_counts(15, "R4 counts");
        tb_sel_i = 0;

        // R11 low priority when both strobes active
        @(negedge clk); rd_lo_n_i = 0; hi_cs_n_i = 0; hi_rd_n_i = 0;
        #1 chk(rd_data_o == 15, "R11 priority", rd_data_o, 15);
        rd_lo_n_i = 1; hi_cs_n_i = 1; hi_rd_n_i = 1;
        // R11 select without read strobe gives zero
        @(negedge clk); hi_cs_n_i = 0; #1 chk(rd_data_o == 0, "R11 no read", rd_data_o, 0);
        hi_cs_n_i = 1;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule